// File: doc/BRIEF.md
# Programmable Down-Counter Channel

This block is a single 16-bit interval-timer channel reached over an 8-bit bus. Software first writes a control word that either selects how the count is loaded (low byte alone, high byte alone, or low then high) or asks for a snapshot of the running count. It then writes the count through the data address. Once the full value is in, the channel decrements by one on each rising edge of an external count clock. That count clock is sampled and edge-detected inside the block, so all logic runs on the system clock.

The output works in interrupt-on-terminal-count fashion. Programming the channel forces it low. It rises when the count steps down to zero and stays high while the counter wraps and keeps going. It can feed an interrupt request line directly.

The count is read back as two bytes, low byte first. A read returns either the live count or a frozen copy taken by a latch command. Reading never stalls or alters the counting.

Top module: `tmr_channel`

## Requirements
- R1: After reset the read data and the output are 0, the count is 0 and the counter does not decrement.
- R2: A control write (bus_addr=1) is taken only when bits 7:6 equal the channel number CHAN_ID (default 0). Bits 5:4 select the action: 00 latch, 01 load low byte only, 10 load high byte only, 11 load low byte then high byte. A control word carrying another channel number changes nothing.
- R3: In a one-byte load mode the byte not written is cleared: mode 01 gives count {8'h00,data}, mode 10 gives count {data,8'h00}.
- R4: Counting starts only after the whole value is written. In mode 11, the first byte alone halts counting and the count keeps its old value until the second byte arrives.
- R5: A data read (bus_addr=0, bus_rd=1) puts a byte on bus_rdata in the next cycle. Consecutive reads alternate low byte, then high byte.
- R6: Reads, live or latched, never change the count or the counting.
- R7: A latch command copies the count into a hold register. The next two reads return that frozen value, low byte then high byte. After the high byte has been read, reads return the live count again.
- R8: A latch command that arrives while a frozen value is still unread is ignored, and the earlier value is kept.
- R9: A mode control word drives tmr_out low. tmr_out goes high in the cycle the count steps from 1 to 0, then stays high as the count wraps to FFFF and continues.
- R10: A mode control word for this channel resets both the write byte pointer and the read byte pointer to the low byte.
- R11: Each rising edge of cnt_clk gives exactly one decrement, however long cnt_clk stays high, provided each level of cnt_clk lasts at least two system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects the count data port, 1 selects the control word |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cnt_clk | input | 1 | Asynchronous count clock |
| tmr_out | output | 1 | Terminal-count output |

## Verification
The assertions assume that bus_wr and bus_rd are never asserted in the same cycle. They also assume that cnt_clk holds each level for at least two system clocks, so that every rising edge yields one tick. The bench drives the bus one strobe per cycle, with a idle cycle between transfers. It generates count-clock pulses whose high and low phases last three or more system clocks. This lets it wait for each decrement to finish before the next bus access, so every expected count is known in advance.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Access field of the control word (bits 5:4)
  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;
endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= async_in;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prog,
  input  logic          pause,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic          term_out
);
  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      run_q    <= 1'b0;
      term_out <= 1'b0;
    end else if (load_en) begin
      count    <= load_val;
      run_q    <= 1'b1;
      term_out <= 1'b0;
    end else if (prog) begin
      run_q    <= 1'b0;
      term_out <= 1'b0;
    end else if (pause) begin
      run_q    <= 1'b0;
    end else if (run_q && tick) begin
      count <= count - 1'b1;
      if (count == CW'(1)) term_out <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_readback.sv
module tmr_readback #(
  parameter int BW = 8,
  localparam int CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic          latch_req,
  input  logic          clr,
  input  logic          rd_en,
  output logic [BW-1:0] rdata,
  output logic [CW-1:0] held,
  output logic          latched
);
  logic          rd_hi_q;
  logic [CW-1:0] src;

  assign src = latched ? held : count;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      held    <= '0;
      latched <= 1'b0;
      rd_hi_q <= 1'b0;
    end else if (clr) begin
      latched <= 1'b0;
      rd_hi_q <= 1'b0;
    end else if (latch_req) begin
      if (!latched) begin
        held    <= count;
        latched <= 1'b1;
        rd_hi_q <= 1'b0;
      end
    end else if (rd_en) begin
      rdata   <= rd_hi_q ? src[CW-1:BW] : src[BW-1:0];
      rd_hi_q <= ~rd_hi_q;
      if (rd_hi_q) latched <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int BYTE_W      = 8,
  parameter int SEL_W       = 2,
  parameter int CHAN_ID     = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              cnt_clk,
  output logic              tmr_out
);
  import tmr_pkg::*;

  localparam int CW     = 2 * BYTE_W;
  localparam int SEL_LO = BYTE_W - SEL_W;
  localparam int ACC_LO_BIT = SEL_LO - 2;
  localparam logic [SEL_W-1:0] CHAN_SEL = CHAN_ID[SEL_W-1:0];

  logic              tick_w;
  logic              ctrl_hit, latch_cmd, prog_cmd, data_wr;
  acc_e              acc_w, mode_q;
  logic              wr_hi_q;
  logic [BYTE_W-1:0] stage_q;
  logic              load_en, pause;
  logic [CW-1:0]     load_val, count_q, held_w;
  logic              latched_w;

  assign ctrl_hit  = bus_wr && bus_addr &&
                     (bus_wdata[BYTE_W-1:SEL_LO] == CHAN_SEL);
  assign acc_w     = acc_e'(bus_wdata[SEL_LO-1:ACC_LO_BIT]);
  assign latch_cmd = ctrl_hit && (acc_w == ACC_LATCH);
  assign prog_cmd  = ctrl_hit && (acc_w != ACC_LATCH);
  assign data_wr   = bus_wr && !bus_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= ACC_LOHI;
      wr_hi_q <= 1'b0;
      stage_q <= '0;
    end else if (prog_cmd) begin
      mode_q  <= acc_w;
      wr_hi_q <= 1'b0;
    end else if (data_wr && mode_q == ACC_LOHI) begin
      wr_hi_q <= ~wr_hi_q;
      if (!wr_hi_q) stage_q <= bus_wdata;
    end
  end

  always_comb begin
    load_en  = 1'b0;
    pause    = 1'b0;
    load_val = '0;
    case (mode_q)
      ACC_LO: begin
        load_en  = data_wr;
        load_val = {{BYTE_W{1'b0}}, bus_wdata};
      end
      ACC_HI: begin
        load_en  = data_wr;
        load_val = {bus_wdata, {BYTE_W{1'b0}}};
      end
      default: begin
        pause    = data_wr && !wr_hi_q;
        load_en  = data_wr && wr_hi_q;
        load_val = {bus_wdata, stage_q};
      end
    endcase
  end

  tmr_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .async_in(cnt_clk), .rise(tick_w)
  );

  tmr_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .prog(prog_cmd), .pause(pause),
    .load_en(load_en), .load_val(load_val), .tick(tick_w),
    .count(count_q), .term_out(tmr_out)
  );

  tmr_readback #(.BW(BYTE_W)) u_rb (
    .clk(clk), .rst(rst), .count(count_q), .latch_req(latch_cmd),
    .clr(prog_cmd), .rd_en(bus_rd && !bus_addr), .rdata(bus_rdata),
    .held(held_w), .latched(latched_w)
  );
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int BYTE_W  = 8,
  parameter int SEL_W   = 2,
  parameter int CHAN_ID = 0,
  localparam int CW     = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_addr,
  input logic              bus_wr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              tmr_out,
  input logic [CW-1:0]     count,
  input logic [CW-1:0]     held,
  input logic              latched,
  input logic [1:0]        mode,
  input logic              tick
);
  localparam int SEL_LO = BYTE_W - SEL_W;
  logic prog_seen, data_seen;

  assign prog_seen = bus_wr && bus_addr &&
                     (bus_wdata[BYTE_W-1:SEL_LO] == CHAN_ID[SEL_W-1:0]) &&
                     (bus_wdata[SEL_LO-1:SEL_LO-2] != 2'b00);
  assign data_seen = bus_wr && !bus_addr;

  assert_prog_low_R9: assert property (@(posedge clk) disable iff (rst)
    prog_seen |=> !tmr_out);

  assert_rise_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(tmr_out) |-> (count == '0));

  assert_zero_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (data_seen && mode == 2'b01) |=> (count[CW-1:BYTE_W] == '0));

  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    latched |=> $stable(held));

  assert_reads_harmless_R6: assert property (@(posedge clk) disable iff (rst)
    (!tick && !data_seen) |=> $stable(count));
endmodule

bind tmr_channel tmr_channel_chk #(
  .BYTE_W(BYTE_W), .SEL_W(SEL_W), .CHAN_ID(CHAN_ID)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .tmr_out(tmr_out), .count(count_q),
  .held(held_w), .latched(latched_w), .mode(mode_q), .tick(tick_w)
);

// File: tb/tmr_channel_test.sv
module tmr_channel_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cnt_clk = 1'b0;
  logic       tmr_out;
  int checks = 0;
  int errors = 0;

  tmr_channel uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_clk(cnt_clk), .tmr_out(tmr_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(output logic [7:0] d);
    @(negedge clk);
    bus_addr = 1'b0; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read16(output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_read(lo);
    bus_read(hi);
    v = {hi, lo};
  endtask

  task automatic pulse(input int n, input int w);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_clk = 1'b1;
      repeat (w) @(negedge clk);
      cnt_clk = 1'b0;
      repeat (w) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 rdata", bus_rdata, 0);
    check("R1 out", tmr_out, 0);
    pulse(2, 3);
    read16(v);
    check("R1 count idle", v, 16'h0000);
  endtask

  task automatic t_one_byte();
    logic [15:0] v;
    bus_write(1'b1, 8'h10);
    bus_write(1'b0, 8'h34);
    read16(v);
    check("R3 low only", v, 16'h0034);
    bus_write(1'b1, 8'h20);
    bus_write(1'b0, 8'h12);
    read16(v);
    check("R3 high only", v, 16'h1200);
    check("R5 last byte high", bus_rdata, 8'h12);
  endtask

  task automatic t_two_byte();
    logic [15:0] v;
    bus_write(1'b1, 8'h30);
    bus_write(1'b0, 8'h05);
    pulse(3, 3);
    read16(v);
    check("R4 halted on first byte", v, 16'h1200);
    bus_write(1'b0, 8'h00);
    pulse(2, 3);
    read16(v);
    check("R4 counting after full load", v, 16'h0003);
    pulse(2, 10);
    check("R9 out low at 1", tmr_out, 0);
    pulse(1, 3);
    check("R9 out high at 0", tmr_out, 1);
    pulse(1, 3);
    read16(v);
    check("R9 wrap", v, 16'hFFFF);
    check("R9 out stays high", tmr_out, 1);
  endtask

  task automatic t_live_read();
    logic [15:0] v;
    logic [7:0]  b;
    bus_write(1'b1, 8'h30);
    check("R9 prog drives low", tmr_out, 0);
    bus_write(1'b0, 8'h0A);
    bus_write(1'b0, 8'h00);
    bus_read(b);
    check("R5 low first", b, 8'h0A);
    pulse(2, 3);
    bus_read(b);
    check("R5 high second", b, 8'h00);
    pulse(3, 4);
    read16(v);
    check("R6 reads harmless", v, 16'h0005);
    check("R11 one step per edge", v, 16'h0005);
  endtask

  task automatic t_latch();
    logic [15:0] v;
    bus_write(1'b1, 8'h30);
    bus_write(1'b0, 8'h00);
    bus_write(1'b0, 8'h01);
    pulse(1, 3);
    bus_write(1'b1, 8'h00);
    pulse(2, 3);
    read16(v);
    check("R7 frozen value", v, 16'h00FF);
    read16(v);
    check("R7 released to live", v, 16'h00FD);
    bus_write(1'b1, 8'h0F);
    pulse(1, 3);
    bus_write(1'b1, 8'h00);
    read16(v);
    check("R8 second latch ignored", v, 16'h00FD);
    read16(v);
    check("R6 count kept going", v, 16'h00FC);
  endtask

  task automatic t_other_chan();
    logic [15:0] v;
    bus_write(1'b1, 8'h30);
    bus_write(1'b1, 8'h50);
    bus_write(1'b0, 8'h22);
    bus_write(1'b0, 8'h01);
    read16(v);
    check("R2 foreign mode word ignored", v, 16'h0122);
    pulse(1, 3);
    bus_write(1'b1, 8'h40);
    pulse(1, 3);
    read16(v);
    check("R2 foreign latch ignored", v, 16'h0120);
  endtask

  task automatic t_ptr_reset();
    logic [15:0] v;
    logic [7:0]  b;
    bus_write(1'b1, 8'h30);
    bus_write(1'b0, 8'h99);
    bus_read(b);
    bus_write(1'b1, 8'h30);
    bus_write(1'b0, 8'h03);
    bus_write(1'b0, 8'h00);
    read16(v);
    check("R10 pointers back to low", v, 16'h0003);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_one_byte();
    t_two_byte();
    t_live_read();
    t_latch();
    t_other_chan();
    t_ptr_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule